// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Selective Invalidation

This block caches recent virtual-to-physical page translations for one requester. Every slot is fully associative and holds a virtual page number, a physical page number, a page size code, the memory attribute index, access permissions, two execute-never bits and four tags: a global/non-global flag, an address-space identifier, a virtual-machine identifier and a security state. A lookup is answered combinationally in the cycle it is presented. The answer is a hit flag, the translated physical address, and the attributes stored with the entry. A miss raises a walk request toward an external table walker. The walker's reply is written into a slot only when it carries no fault.

Software maintenance is expressed as invalidate requests. Each request selects a scope: everything, one identifier, one address under one identifier, one address under any identifier, or one virtual machine. The address-based requests can be narrowed to final-level entries so that large block mappings survive. Slots are chosen for filling by taking the lowest empty slot first and otherwise a rotating pointer.

Top module: `tlbc_top`

## Requirements
- R1: A lookup with `lk_valid` high returns, in the same cycle, `lk_hit`, `lk_pa` = {stored physical page with the page-offset bits taken from the VA, VA[11:0]}, and the stored attribute index, permissions and execute-never bits. After reset no lookup hits.
- R2: An entry filled with `fill_ng` = 0 (global) hits under any current identifier. An entry with `fill_ng` = 1 hits only when its stored identifier equals `cur_asid`.
- R3: With `cfg_asid16` = 1 all 16 identifier bits are compared. With `cfg_asid16` = 0 only bits [7:0] are compared, for lookups and for invalidates alike.
- R4: An entry records `cur_secure` at fill time, and a lookup hits it only while `cur_secure` has the same value.
- R5: `walk_req` equals `lk_valid` and not `lk_hit`. A fill with `fill_fault` = 1 writes nothing.
- R6: Size codes are 0 = 4 KB, 1 = 64 KB contiguous (VA[15:12] ignored), 2 = 2 MB block (VA[20:12] ignored) and 3 = 1 GB block (VA[29:12] ignored). The ignored bits of the physical page come from the VA.
- R7: `inv_op` codes are 0 = all entries, 1 = non-global entries with identifier `inv_asid`, 2 = entries covering `inv_vpn` that are global or carry `inv_asid`, 3 = entries covering `inv_vpn` under any identifier, and 4 = all entries of `cur_vmid`. Codes 1 to 3 only touch entries with the current VMID and security state.
- R8: When `inv_last` = 1, codes 2 and 3 remove only final-level entries (sizes 0 and 1), and block entries (sizes 2 and 3) stay.
- R9: A global entry survives code 1 but is removed by code 3.
- R10: An entry hit by an invalidate is gone from the following cycle on, and a lookup in the request cycle itself does not hit it.
- R11: A fill goes to the lowest-numbered empty slot. When every slot is full it goes to the rotating pointer, which then advances by one and wraps.
- R12: An entry records `cur_vmid` at fill time and hits only while `cur_vmid` has the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_asid16 | input | 1 | 1 selects 16-bit identifier compare, 0 selects 8-bit |
| cur_asid | input | 16 | Current address-space identifier |
| cur_vmid | input | 8 | Current virtual-machine identifier |
| cur_secure | input | 1 | Current security state |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 48 | Translated physical address |
| lk_attr | output | 3 | Memory attribute index of the hit |
| lk_perm | output | 2 | Access permissions of the hit |
| lk_xn | output | 2 | Execute-never bits {unprivileged, privileged} |
| walk_req | output | 1 | Miss, walk requested |
| fill_valid | input | 1 | Walker reply present |
| fill_fault | input | 1 | Walker reply is a fault |
| fill_vpn | input | 36 | Virtual page number of the reply |
| fill_ppn | input | 36 | Physical page number of the reply |
| fill_size | input | 2 | Page size code |
| fill_ng | input | 1 | Non-global flag |
| fill_attr | input | 3 | Attribute index |
| fill_perm | input | 2 | Permissions |
| fill_xn | input | 2 | Execute-never bits |
| inv_valid | input | 1 | Invalidate request |
| inv_op | input | 3 | Invalidate scope code |
| inv_last | input | 1 | Restrict to final-level entries |
| inv_vpn | input | 36 | Virtual page for address-based scopes |
| inv_asid | input | 16 | Identifier for identifier-based scopes |

## Verification
A lookup and an invalidate can fall in the same cycle. The bench provokes this by driving both on one low clock phase, once with the invalidate aimed at the looked-up page and once at another page. It expects no hit in the first case and an unaffected hit in the second, and in the first case it also checks for a miss in the next cycle. Fill placement is swept over more fills than there are slots, and after every fill the whole resident set is predicted by arithmetic.

// File: rtl/tlbc_pkg.sv
// Shared widths, encodings and entry layout for the translation cache.
// Assumes 4 KB base pages; larger pages are expressed by a size code.
package tlbc_pkg;
    parameter int VA_W   = 48;
    parameter int PA_W   = 48;
    parameter int PG_SH  = 12;
    parameter int ASID_W = 16;
    parameter int VMID_W = 8;
    localparam int VPN_W = VA_W - PG_SH;
    localparam int PPN_W = PA_W - PG_SH;

    typedef enum logic [1:0] {PG_4K = 2'd0, PG_64K = 2'd1, PG_2M = 2'd2, PG_1G = 2'd3} pg_size_e;

    typedef enum logic [2:0] {
        INV_ALL = 3'd0, INV_ASID = 3'd1, INV_VA_ASID = 3'd2,
        INV_VA_ANY = 3'd3, INV_VMID = 3'd4
    } inv_op_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        pg_size_e          size;
        logic              ng;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic              sec;
        logic [2:0]        attr;
        logic [1:0]        perm;
        logic [1:0]        xn;
    } tlb_ent_t;

    // Number of low page-number bits that a page size leaves untranslated.
    function automatic int unsigned size_shift(pg_size_e s);
        case (s)
            PG_64K:  return 4;
            PG_2M:   return 9;
            PG_1G:   return 18;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/tlbc_match.sv
// Compare logic for one slot: lookup match, translated page and invalidate kill.
// Assumes the caller gates results with the slot's valid bit.
module tlbc_match
    import tlbc_pkg::*;
(
    input  tlb_ent_t                ent,
    input  logic [VPN_W-1:0]        lk_vpn,
    input  logic [ASID_W-1:0]       cur_asid,
    input  logic [VMID_W-1:0]       cur_vmid,
    input  logic                    cur_secure,
    input  logic                    cfg_asid16,
    input  logic                    inv_en,
    input  logic [2:0]              inv_op,
    input  logic                    inv_last,
    input  logic [VPN_W-1:0]        inv_vpn,
    input  logic [ASID_W-1:0]       inv_asid,
    output logic                    hit_raw,
    output logic                    kill,
    output logic [PPN_W-1:0]        pa_ppn
);
    logic [VPN_W-1:0] vmask;
    logic [PPN_W-1:0] pmask;
    logic             ctx_eq, vm_eq, cur_id_eq, inv_id_eq, inv_va_eq, last_ok;

    // Identifier compare honouring the configured width.
    function automatic logic id_eq(input logic [ASID_W-1:0] a, input logic [ASID_W-1:0] b, input logic wide);
        return wide ? (a == b) : (a[7:0] == b[7:0]);
    endfunction

    // Masks and tag comparisons shared by lookup and invalidate.
    always_comb begin
        vmask     = {VPN_W{1'b1}} << size_shift(ent.size);
        pmask     = {PPN_W{1'b1}} << size_shift(ent.size);
        vm_eq     = (ent.vmid == cur_vmid);
        ctx_eq    = vm_eq && (ent.sec == cur_secure);
        cur_id_eq = id_eq(ent.asid, cur_asid, cfg_asid16);
        inv_id_eq = id_eq(ent.asid, inv_asid, cfg_asid16);
        inv_va_eq = (((inv_vpn ^ ent.vpn) & vmask) == '0);
        last_ok   = !inv_last || (ent.size == PG_4K) || (ent.size == PG_64K);
    end

    // Lookup match and page merge.
    always_comb begin
        hit_raw = ctx_eq && (((lk_vpn ^ ent.vpn) & vmask) == '0) && (!ent.ng || cur_id_eq);
        pa_ppn  = (ent.ppn & pmask) | (PPN_W'(lk_vpn) & ~pmask);
    end

    // Invalidate scope decode.
    always_comb begin
        case (inv_op_e'(inv_op))
            INV_ALL:     kill = 1'b1;
            INV_ASID:    kill = ctx_eq && ent.ng && inv_id_eq;
            INV_VA_ASID: kill = ctx_eq && inv_va_eq && last_ok && (!ent.ng || inv_id_eq);
            INV_VA_ANY:  kill = ctx_eq && inv_va_eq && last_ok;
            INV_VMID:    kill = vm_eq;
            default:     kill = 1'b0;
        endcase
        kill = kill && inv_en;
    end
endmodule

// File: rtl/tlbc_victim.sv
// Fill slot selection: lowest empty slot first, else a rotating pointer.
// Assumes N >= 2; the pointer advances only when a full cache is filled.
module tlbc_victim #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             fill_we,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
    logic [IDX_W-1:0] rr_q;
    logic             any_free;

    // Priority pick of the lowest empty slot.
    always_comb begin
        victim   = rr_q;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                victim   = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Rotating pointer update on replacement of a full cache.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_we && !any_free)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R11: an empty slot is always preferred.
    p_prefer_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid) |-> !valid[victim]);
    // R11: a full-cache fill moves the pointer by one.
    p_rr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && (&valid)) |=> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));
endmodule

// File: rtl/tlbc_top.sv
// Fully associative translation cache with context tags and scoped invalidates.
// Lookups are combinational; fills and invalidates update state at the clock edge.
// Assumes the walker never returns a translation that is already resident.
module tlbc_top
    import tlbc_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_asid16,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic              cur_secure,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [2:0]        lk_attr,
    output logic [1:0]        lk_perm,
    output logic [1:0]        lk_xn,
    output logic              walk_req,
    input  logic              fill_valid,
    input  logic              fill_fault,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [1:0]        fill_size,
    input  logic              fill_ng,
    input  logic [2:0]        fill_attr,
    input  logic [1:0]        fill_perm,
    input  logic [1:0]        fill_xn,
    input  logic              inv_valid,
    input  logic [2:0]        inv_op,
    input  logic              inv_last,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid
);
    tlb_ent_t          ents [N];
    logic [N-1:0]      valid_q, hit_raw, kill, hit_vec;
    logic [PPN_W-1:0]  ppn_v [N];
    logic [IDX_W-1:0]  victim;
    logic              fill_we;
    tlb_ent_t          new_ent;

    assign fill_we = fill_valid && !fill_fault;

    // Assemble the entry written by a fill.
    always_comb begin
        new_ent      = '0;
        new_ent.vpn  = fill_vpn;
        new_ent.ppn  = fill_ppn;
        new_ent.size = pg_size_e'(fill_size);
        new_ent.ng   = fill_ng;
        new_ent.asid = cur_asid;
        new_ent.vmid = cur_vmid;
        new_ent.sec  = cur_secure;
        new_ent.attr = fill_attr;
        new_ent.perm = fill_perm;
        new_ent.xn   = fill_xn;
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        tlbc_match i_match (
            .ent(ents[g]), .lk_vpn(lk_va[VA_W-1:PG_SH]), .cur_asid(cur_asid),
            .cur_vmid(cur_vmid), .cur_secure(cur_secure), .cfg_asid16(cfg_asid16),
            .inv_en(inv_valid), .inv_op(inv_op), .inv_last(inv_last),
            .inv_vpn(inv_vpn), .inv_asid(inv_asid),
            .hit_raw(hit_raw[g]), .kill(kill[g]), .pa_ppn(ppn_v[g])
        );

        // R10: a killed slot is empty one cycle later unless refilled.
        p_kill_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (kill[g] && !(fill_we && victim == IDX_W'(g))) |=> !valid_q[g]);
    end

    tlbc_victim #(.N(N)) i_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_we(fill_we), .victim(victim)
    );

    // Live hits exclude slots being invalidated this cycle.
    assign hit_vec = hit_raw & valid_q & ~kill;

    // Output selection, lowest hitting slot wins.
    always_comb begin
        lk_hit  = 1'b0;
        lk_pa   = '0;
        lk_attr = '0;
        lk_perm = '0;
        lk_xn   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_valid && hit_vec[i]) begin
                lk_hit  = 1'b1;
                lk_pa   = {ppn_v[i], lk_va[PG_SH-1:0]};
                lk_attr = ents[i].attr;
                lk_perm = ents[i].perm;
                lk_xn   = ents[i].xn;
            end
        end
        walk_req = lk_valid && !lk_hit;
    end

    // Valid bits: clear on invalidate, set on an accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~kill;
            if (fill_we)
                valid_q[victim] <= 1'b1;
        end
    end

    // Entry payload storage, written only by accepted fills.
    always_ff @(posedge clk) begin
        if (fill_we)
            ents[victim] <= new_ent;
    end

    // R5: a faulted reply leaves the valid set untouched.
    p_fault_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_fault && !inv_valid) |=> (valid_q == $past(valid_q)));
    // R7: a full flush request never coincides with a hit.
    p_flush_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_op == 3'd0) |-> !lk_hit);
    // R5: a walk is requested only for a real miss.
    p_walk_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (lk_valid && !lk_hit));
endmodule

// File: tb/test_tlbc_top.sv
module test_tlbc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_asid16 = 1'b1;
    logic [15:0] cur_asid = 16'h0012;
    logic [7:0]  cur_vmid = 8'd1;
    logic        cur_secure = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic        lk_hit, walk_req;
    logic [47:0] lk_pa;
    logic [2:0]  lk_attr;
    logic [1:0]  lk_perm, lk_xn;
    logic        fill_valid = 1'b0, fill_fault = 1'b0, fill_ng = 1'b0;
    logic [35:0] fill_vpn = '0, fill_ppn = '0;
    logic [1:0]  fill_size = '0, fill_perm = '0, fill_xn = '0;
    logic [2:0]  fill_attr = '0;
    logic        inv_valid = 1'b0, inv_last = 1'b0;
    logic [2:0]  inv_op = '0;
    logic [35:0] inv_vpn = '0;
    logic [15:0] inv_asid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlbc_top #(.N(4)) i_tlbc_top (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [15:0] a, input logic [7:0] v, input bit s, input bit w);
        @(negedge clk);
        cur_asid = a; cur_vmid = v; cur_secure = s; cfg_asid16 = w;
    endtask

    // Attributes are derived from the filled page number: attr=ppn[2:0], perm=ppn[4:3], xn=ppn[6:5].
    task automatic fill(input logic [35:0] vpn, input logic [35:0] ppn, input logic [1:0] sz,
                        input bit ng, input bit flt);
        @(negedge clk);
        fill_valid = 1'b1; fill_fault = flt; fill_vpn = vpn; fill_ppn = ppn;
        fill_size = sz; fill_ng = ng; fill_attr = ppn[2:0]; fill_perm = ppn[4:3]; fill_xn = ppn[6:5];
        @(negedge clk);
        fill_valid = 1'b0; fill_fault = 1'b0;
    endtask

    task automatic inv(input logic [2:0] op, input bit last, input logic [35:0] vpn, input logic [15:0] asid);
        @(negedge clk);
        inv_valid = 1'b1; inv_op = op; inv_last = last; inv_vpn = vpn; inv_asid = asid;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic look(input logic [35:0] vpn, input bit eh, input logic [35:0] eppn,
                        input logic [35:0] src, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = {vpn, 12'hABC};
        #2;
        chk(lk_hit == eh, {tag, " hit"}, 64'(lk_hit), 64'(eh));
        chk(walk_req == !eh, {tag, " walk_req R5"}, 64'(walk_req), 64'(!eh));
        if (eh) begin
            chk(lk_pa == {eppn, 12'hABC}, {tag, " pa R1"}, 64'(lk_pa), 64'({eppn, 12'hABC}));
            chk({lk_attr, lk_perm, lk_xn} == {src[2:0], src[4:3], src[6:5]}, {tag, " attrs R1"},
                64'({lk_attr, lk_perm, lk_xn}), 64'({src[2:0], src[4:3], src[6:5]}));
        end
        lk_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        look(36'h5, 1'b0, '0, '0, "R1 reset");

        // R11: sweep of ten fills over four slots; resident set is the last four
        for (int k = 0; k < 10; k++) begin
            fill(36'h100 + 36'(k), 36'h800 + 36'(k), 2'd0, 1'b0, 1'b0);
            for (int j = 0; j < 10; j++) begin
                bit e;
                e = (j <= k) && (j > k - 4);
                look(36'h100 + 36'(j), e, 36'h800 + 36'(j), 36'h800 + 36'(j), "R11 sweep");
            end
        end
        // slots now 0:108 1:109 2:106 3:107, pointer at 2
        inv(3'd3, 1'b0, 36'h109, '0);
        fill(36'h10A, 36'h80A, 2'd0, 1'b0, 1'b0);   // empty slot 1
        fill(36'h10B, 36'h80B, 2'd0, 1'b0, 1'b0);   // pointer slot 2 replaces 106
        look(36'h106, 1'b0, '0, '0, "R11 pointer victim");
        look(36'h107, 1'b1, 36'h807, 36'h807, "R11 kept");
        look(36'h108, 1'b1, 36'h808, 36'h808, "R11 kept");
        look(36'h109, 1'b0, '0, '0, "R11 invalidated");
        look(36'h10A, 1'b1, 36'h80A, 36'h80A, "R11 empty first");
        look(36'h10B, 1'b1, 36'h80B, 36'h80B, "R11 replaced");
        inv(3'd0, 1'b0, '0, '0);
        for (int j = 7; j < 12; j++)
            look(36'h100 + 36'(j), 1'b0, '0, '0, "R7 flush all");

        // R2 / R3: global and non-global, identifier width
        set_ctx(16'h1234, 8'd1, 1'b0, 1'b1);
        fill(36'h200, 36'h0F5, 2'd0, 1'b1, 1'b0);
        fill(36'h201, 36'h06A, 2'd0, 1'b0, 1'b0);
        look(36'h200, 1'b1, 36'h0F5, 36'h0F5, "R2 ng own id");
        look(36'h201, 1'b1, 36'h06A, 36'h06A, "R2 global");
        set_ctx(16'h1235, 8'd1, 1'b0, 1'b1);
        look(36'h200, 1'b0, '0, '0, "R2 ng other id");
        look(36'h201, 1'b1, 36'h06A, 36'h06A, "R2 global other id");
        set_ctx(16'h5634, 8'd1, 1'b0, 1'b1);
        look(36'h200, 1'b0, '0, '0, "R3 16-bit compare");
        set_ctx(16'h5634, 8'd1, 1'b0, 1'b0);
        look(36'h200, 1'b1, 36'h0F5, 36'h0F5, "R3 8-bit compare");
        set_ctx(16'h1235, 8'd1, 1'b0, 1'b0);
        look(36'h200, 1'b0, '0, '0, "R3 8-bit mismatch");

        // R4 / R12: security and VMID tags
        set_ctx(16'h1234, 8'd1, 1'b1, 1'b1);
        look(36'h201, 1'b0, '0, '0, "R4 other security");
        set_ctx(16'h1234, 8'd2, 1'b0, 1'b1);
        look(36'h201, 1'b0, '0, '0, "R12 other vmid");
        set_ctx(16'h1234, 8'd1, 1'b0, 1'b1);
        look(36'h201, 1'b1, 36'h06A, 36'h06A, "R4 R12 own context");

        // R6: contiguous and block sizes
        inv(3'd0, 1'b0, '0, '0);
        fill(36'h310, 36'h520, 2'd1, 1'b0, 1'b0);
        look(36'h31A, 1'b1, 36'h52A, 36'h520, "R6 contiguous inside");
        look(36'h320, 1'b0, '0, '0, "R6 contiguous above");
        look(36'h30F, 1'b0, '0, '0, "R6 contiguous below");
        fill(36'h4000, 36'h8000, 2'd2, 1'b0, 1'b0);
        look(36'h4123, 1'b1, 36'h8123, 36'h8000, "R6 2MB block");
        look(36'h4200, 1'b0, '0, '0, "R6 2MB outside");
        fill(36'h80000, 36'hC0000, 2'd3, 1'b0, 1'b0);
        look(36'hBFFFF, 1'b1, 36'hFFFFF, 36'hC0000, "R6 1GB block");

        // R5: faulted reply not stored
        inv(3'd0, 1'b0, '0, '0);
        fill(36'h600, 36'h111, 2'd0, 1'b0, 1'b1);
        look(36'h600, 1'b0, '0, '0, "R5 fault not filled");

        // R7 / R8 / R9: scoped invalidates
        inv(3'd0, 1'b0, '0, '0);
        set_ctx(16'h0012, 8'd1, 1'b0, 1'b1);
        fill(36'h700, 36'h170, 2'd0, 1'b1, 1'b0);    // A non-global id 12
        fill(36'h701, 36'h171, 2'd0, 1'b0, 1'b0);    // B global
        fill(36'h800, 36'h400, 2'd2, 1'b1, 1'b0);    // D 2MB block id 12
        set_ctx(16'h0034, 8'd1, 1'b0, 1'b1);
        fill(36'h702, 36'h172, 2'd0, 1'b1, 1'b0);    // C non-global id 34
        inv(3'd1, 1'b0, '0, 16'h0012);
        look(36'h702, 1'b1, 36'h172, 36'h172, "R7 by-id keeps other id");
        look(36'h701, 1'b1, 36'h171, 36'h171, "R9 by-id keeps global");
        set_ctx(16'h0012, 8'd1, 1'b0, 1'b1);
        look(36'h700, 1'b0, '0, '0, "R7 by-id removes");
        look(36'h812, 1'b0, '0, '0, "R7 by-id removes block");
        fill(36'h700, 36'h170, 2'd0, 1'b1, 1'b0);
        fill(36'h800, 36'h400, 2'd2, 1'b1, 1'b0);
        inv(3'd2, 1'b0, 36'h702, 16'h0012);
        inv(3'd2, 1'b0, 36'h700, 16'h0012);
        look(36'h700, 1'b0, '0, '0, "R7 by-va-id removes");
        set_ctx(16'h0034, 8'd1, 1'b0, 1'b1);
        look(36'h702, 1'b1, 36'h172, 36'h172, "R7 by-va-id keeps other id");
        inv(3'd3, 1'b1, 36'h800, '0);
        set_ctx(16'h0012, 8'd1, 1'b0, 1'b1);
        look(36'h805, 1'b1, 36'h405, 36'h400, "R8 last-level keeps block");
        inv(3'd3, 1'b0, 36'h701, '0);
        look(36'h701, 1'b0, '0, '0, "R9 by-va-any removes global");
        inv(3'd3, 1'b0, 36'h8AB, '0);
        look(36'h805, 1'b0, '0, '0, "R8 full removes block");
        inv(3'd3, 1'b1, 36'h702, '0);
        set_ctx(16'h0034, 8'd1, 1'b0, 1'b1);
        look(36'h702, 1'b0, '0, '0, "R7 by-va-any any id");
        fill(36'h900, 36'h190, 2'd0, 1'b0, 1'b0);
        set_ctx(16'h0034, 8'd2, 1'b0, 1'b1);
        fill(36'h901, 36'h191, 2'd0, 1'b0, 1'b0);
        inv(3'd4, 1'b0, '0, '0);
        look(36'h901, 1'b0, '0, '0, "R7 by-vmid removes");
        set_ctx(16'h0034, 8'd1, 1'b0, 1'b1);
        look(36'h900, 1'b1, 36'h190, 36'h190, "R7 by-vmid keeps other vmid");

        // R10: lookup and invalidate in the same cycle
        fill(36'hA00, 36'h2A0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        inv_valid = 1'b1; inv_op = 3'd3; inv_last = 1'b0; inv_vpn = 36'h900; lk_valid = 1'b1; lk_va = {36'hA00, 12'h010};
        #2;
        chk(lk_hit == 1'b1, "R10 other page unaffected", 64'(lk_hit), 64'd1);
        @(negedge clk);
        inv_vpn = 36'hA00;
        #2;
        chk(lk_hit == 1'b0, "R10 same-cycle kill", 64'(lk_hit), 64'd0);
        @(negedge clk);
        inv_valid = 1'b0;
        #2;
        chk(lk_hit == 1'b0, "R10 gone next cycle", 64'(lk_hit), 64'd0);
        lk_valid = 1'b0;
        look(36'h900, 1'b0, '0, '0, "R10 first kill held");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule